// File: doc/BRIEF.md
# Up/Down PWM Compare Timer

This block is a single-channel pulse-width timer. A counter runs against a programmable reload limit and a compare value, and a registered reference output is derived from them. Three counting schemes are available. The edge-aligned upward scheme wraps from the limit to zero. The edge-aligned downward scheme reloads from zero to the limit. The center-aligned scheme climbs to the limit and falls back to zero, turning at each end without repeating the end value. A sticky match flag records when the count hits the compare value, and software clears it with a one-cycle strobe.

The counting direction is held in a four-state machine. The states are `ST_EDGE_UP`, `ST_EDGE_DN`, `ST_CTR_UP` and `ST_CTR_DN`, and reset enters `ST_EDGE_UP`. On an enabled cycle in edge mode the next state is `ST_EDGE_DN` when the direction input is 1 and `ST_EDGE_UP` when it is 0. When center mode is entered from `ST_EDGE_UP` or `ST_CTR_UP`, the machine stays rising (`ST_CTR_UP`) until the count reaches the limit. It then takes the turn-down transition to `ST_CTR_DN`. When center mode is entered from `ST_EDGE_DN` or `ST_CTR_DN`, the machine stays falling until the count reaches 0. It then takes the turn-up transition to `ST_CTR_UP`. While the enable is low, the state and the count hold.

The reload, compare and mode inputs act directly, with no shadow copies. The alignment field `align_sel` chooses the scheme: 00 is edge-aligned, and any other code is center-aligned. In center mode the same code also picks the flag filter.

Top module: `pwm_updown_timer`

## Requirements
- R1: During and right after reset, `count` is 0, `pwm_ref` is 0, `cmp_flag` is 0, and the machine is in the rising edge state.
- R2: With `align_sel`=00, `dir_down`=0 and `en`=1, the next count is 0 when the count is at or above `reload`, and count+1 otherwise. The period is `reload`+1 clocks.
- R3: With `align_sel`=00, `dir_down`=1 and `en`=1, the next count is `reload` when the count is 0, and count-1 otherwise.
- R4: With `align_sel`≠00 and `en`=1, a rising count steps up by 1 until it is at or above `reload`, then steps down by 1 (0 stays 0). A falling count steps down by 1 until it reaches 0, then goes to 1 (to 0 when `reload`=0).
- R5: With `en`=0, `count` and the direction state hold, and no match sets the flag.
- R6: In rising edge mode, `pwm_ref` is registered one cycle after the count: it is 1 when count < `cmp_val` and 0 otherwise.
- R7: In falling edge mode, `pwm_ref` (one cycle later) is 1 when count ≤ `cmp_val` and 0 otherwise, so a 0% duty cycle is never produced.
- R8: When `cmp_val` > `reload`, `pwm_ref` is 1 on the next cycle in every mode.
- R9: In rising edge mode with `cmp_val`=0, `pwm_ref` is 0 on the next cycle.
- R10: In edge mode, an enabled cycle with count = `cmp_val` sets `cmp_flag` on the next cycle. The flag then stays set until a cycle with `flag_clr`=1 and no set. When a set and a clear coincide, the set wins.
- R11: In center mode the flag is set only by matches in the chosen direction. Code 01 selects falling, 10 selects rising and 11 selects both. The direction is that of the state before the step, and the end values count with the direction that reached them.
- R12: All three center codes drive `pwm_ref` with the rising rule of R6, together with the saturation rule of R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Count enable |
| reload | input | CNT_W | Period limit |
| cmp_val | input | CNT_W | Compare value |
| align_sel | input | 2 | 00 edge-aligned; 01/10/11 center with flag on falling/rising/both |
| dir_down | input | 1 | Edge-mode direction, 1 counts down |
| flag_clr | input | 1 | Clear strobe for the match flag |
| pwm_ref | output | 1 | Registered reference PWM output |
| cmp_flag | output | 1 | Sticky compare-match flag |
| count | output | CNT_W | Current counter value |

## Verification
The bench drives compare values of 0, equal to the limit and above the limit in each scheme. A design that mixed up the saturation rules would show a stuck-low output where it must stay high, or a zero-duty output in falling mode. Center runs with each nonzero code check the turning points. An off-by-one at a turn would repeat the end value, and a wrong filter would raise the flag on a match in the wrong direction. The bench also holds the clear strobe high across a match, which catches a flag whose clear beats its set. It changes the limit while the counter is running and toggles the enable mid-period, which exposes counters that run while disabled or that hang when the count sits above a lowered limit.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        ST_EDGE_UP = 2'b00,
        ST_EDGE_DN = 2'b01,
        ST_CTR_UP  = 2'b10,
        ST_CTR_DN  = 2'b11
    } cnt_state_e;

    typedef enum logic {
        RULE_BELOW   = 1'b0,
        RULE_NOT_ABOVE = 1'b1
    } level_rule_e;

    localparam logic [1:0] ALIGN_EDGE    = 2'b00;
    localparam logic [1:0] CTR_FLAG_DN   = 2'b01;
    localparam logic [1:0] CTR_FLAG_UP   = 2'b10;
    localparam logic [1:0] CTR_FLAG_BOTH = 2'b11;

endpackage

// File: rtl/pwm_cnt_fsm.sv
module pwm_cnt_fsm
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    input  logic [1:0]       align_sel,
    input  logic             dir_down,
    output logic [CNT_W-1:0] cnt_q,
    output logic             rising
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             edge_mode;
    logic             at_top;
    logic             at_bottom;

    assign edge_mode = (align_sel == ALIGN_EDGE);
    assign at_top    = (cnt_q >= reload);
    assign at_bottom = (cnt_q == CNT_ZERO);

    // Direction of the count held in the current state
    always_comb begin
        unique case (state_q)
            ST_EDGE_UP, ST_CTR_UP: rising = 1'b1;
            ST_EDGE_DN, ST_CTR_DN: rising = 1'b0;
            default:               rising = 1'b1;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EDGE_UP;
            cnt_q   <= CNT_ZERO;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and next count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (en) begin
            if (edge_mode) begin
                if (dir_down) begin
                    state_d = ST_EDGE_DN;
                    cnt_d   = at_bottom ? reload : (cnt_q - CNT_ONE);
                end else begin
                    state_d = ST_EDGE_UP;
                    cnt_d   = at_top ? CNT_ZERO : (cnt_q + CNT_ONE);
                end
            end else begin
                unique case (state_q)
                    ST_EDGE_UP, ST_CTR_UP: begin
                        if (at_top) begin
                            state_d = ST_CTR_DN;
                            cnt_d   = at_bottom ? CNT_ZERO : (cnt_q - CNT_ONE);
                        end else begin
                            state_d = ST_CTR_UP;
                            cnt_d   = cnt_q + CNT_ONE;
                        end
                    end
                    ST_EDGE_DN, ST_CTR_DN: begin
                        if (at_bottom) begin
                            state_d = ST_CTR_UP;
                            cnt_d   = (reload == CNT_ZERO) ? CNT_ZERO : CNT_ONE;
                        end else begin
                            state_d = ST_CTR_DN;
                            cnt_d   = cnt_q - CNT_ONE;
                        end
                    end
                    default: begin
                        state_d = ST_EDGE_UP;
                        cnt_d   = CNT_ZERO;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pwm_level_gen.sv
module pwm_level_gen
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       align_sel,
    input  logic             dir_down,
    output logic             level_q
);

    level_rule_e rule;
    logic        saturate;
    logic        level_d;

    assign saturate = (cmp_val > reload);

    always_comb begin
        if ((align_sel == ALIGN_EDGE) && dir_down) begin
            rule = RULE_NOT_ABOVE;
        end else begin
            rule = RULE_BELOW;
        end
    end

    always_comb begin
        unique case (rule)
            RULE_BELOW:     level_d = saturate | (cnt < cmp_val);
            RULE_NOT_ABOVE: level_d = saturate | (cnt <= cmp_val);
            default:        level_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

endmodule

// File: rtl/pwm_match_flag.sv
module pwm_match_flag
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       align_sel,
    input  logic             rising,
    input  logic             flag_clr,
    output logic             flag_q
);

    logic hit;
    logic dir_ok;
    logic set_now;

    assign hit = (cnt == cmp_val);

    always_comb begin
        unique case (align_sel)
            ALIGN_EDGE:    dir_ok = 1'b1;
            CTR_FLAG_DN:   dir_ok = ~rising;
            CTR_FLAG_UP:   dir_ok = rising;
            CTR_FLAG_BOTH: dir_ok = 1'b1;
            default:       dir_ok = 1'b0;
        endcase
    end

    assign set_now = en & hit & dir_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_now) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_updown_timer.sv
module pwm_updown_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [1:0]       align_sel,
    input  logic             dir_down,
    input  logic             flag_clr,
    output logic             pwm_ref,
    output logic             cmp_flag,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] cnt_w;
    logic             rising_w;

    pwm_cnt_fsm #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .reload    (reload),
        .align_sel (align_sel),
        .dir_down  (dir_down),
        .cnt_q     (cnt_w),
        .rising    (rising_w)
    );

    pwm_level_gen #(.CNT_W(CNT_W)) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt_w),
        .reload    (reload),
        .cmp_val   (cmp_val),
        .align_sel (align_sel),
        .dir_down  (dir_down),
        .level_q   (pwm_ref)
    );

    pwm_match_flag #(.CNT_W(CNT_W)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cnt       (cnt_w),
        .cmp_val   (cmp_val),
        .align_sel (align_sel),
        .rising    (rising_w),
        .flag_clr  (flag_clr),
        .flag_q    (cmp_flag)
    );

    assign count = cnt_w;

endmodule

// File: rtl/pwm_updown_timer_chk.sv
module pwm_updown_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic [CNT_W-1:0] reload,
    input logic [CNT_W-1:0] cmp_val,
    input logic [1:0]       align_sel,
    input logic             dir_down,
    input logic             flag_clr,
    input logic             pwm_ref,
    input logic             cmp_flag,
    input logic [CNT_W-1:0] count
);

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(count));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !flag_clr) |=> cmp_flag);

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && align_sel == 2'b00 && count == cmp_val && flag_clr) |=> cmp_flag);

    // R8
    saturate_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_val > reload) |=> pwm_ref);

    // R9
    zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (align_sel == 2'b00 && !dir_down && cmp_val == '0) |=> !pwm_ref);

    // R2
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && align_sel == 2'b00 && !dir_down && count >= reload) |=> (count == '0));

    // R3
    down_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && align_sel == 2'b00 && dir_down && count == '0) |=> (count == $past(reload)));

endmodule

bind pwm_updown_timer pwm_updown_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .reload    (reload),
    .cmp_val   (cmp_val),
    .align_sel (align_sel),
    .dir_down  (dir_down),
    .flag_clr  (flag_clr),
    .pwm_ref   (pwm_ref),
    .cmp_flag  (cmp_flag),
    .count     (count)
);

// File: tb/pwm_updown_timer_tb_top.sv
`timescale 1ns/1ps
module pwm_updown_timer_tb_top;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic [CNT_W-1:0] reload = '0;
    logic [CNT_W-1:0] cmp_val = '0;
    logic [1:0]       align_sel = 2'b00;
    logic             dir_down = 1'b0;
    logic             flag_clr = 1'b0;
    logic             pwm_ref;
    logic             cmp_flag;
    logic [CNT_W-1:0] count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    int m_cnt;
    bit m_up;
    bit m_pwm;
    bit m_flag;

    always #5 clk = ~clk;

    pwm_updown_timer #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .reload(reload), .cmp_val(cmp_val),
        .align_sel(align_sel), .dir_down(dir_down), .flag_clr(flag_clr),
        .pwm_ref(pwm_ref), .cmp_flag(cmp_flag), .count(count)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_level(int c, int rl, int cv, int al, bit dn);
        if (cv > rl) return 1'b1;
        if (al == 0 && dn) return c <= cv;
        return c < cv;
    endfunction

    // one clock step: model next state, advance, compare
    task automatic step();
        int  rl = int'(reload);
        int  cv = int'(cmp_val);
        int  al = int'(align_sel);
        int  n_cnt = m_cnt;
        bit  n_up = m_up;
        bit  dir_ok;
        bit  n_pwm;
        bit  n_flag;
        string cnt_tag, pwm_tag, flg_tag;
        if (en) begin
            if (al == 0) begin
                n_up = !dir_down;
                if (dir_down) n_cnt = (m_cnt == 0) ? rl : m_cnt - 1;
                else          n_cnt = (m_cnt >= rl) ? 0 : m_cnt + 1;
            end else if (m_up) begin
                if (m_cnt >= rl) begin n_up = 0; n_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
                else n_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin n_up = 1; n_cnt = (rl == 0) ? 0 : 1; end
                else n_cnt = m_cnt - 1;
            end
        end
        n_pwm = exp_level(m_cnt, rl, cv, al, dir_down);
        dir_ok = (al == 0) || (al == 3) || (al == 2 && m_up) || (al == 1 && !m_up);
        if (en && m_cnt == cv && dir_ok) n_flag = 1'b1;
        else if (flag_clr)               n_flag = 1'b0;
        else                             n_flag = m_flag;
        if (!en)                 cnt_tag = "R5 count hold";
        else if (al != 0)        cnt_tag = "R4 center count";
        else if (dir_down)       cnt_tag = "R3 down count";
        else                     cnt_tag = "R2 up count";
        if (cv > rl)             pwm_tag = "R8 saturate";
        else if (al != 0)        pwm_tag = "R12 center level";
        else if (dir_down)       pwm_tag = "R7 down level";
        else if (cv == 0)        pwm_tag = "R9 zero duty";
        else                     pwm_tag = "R6 up level";
        if (!en)                 flg_tag = "R5 flag no set";
        else if (al != 0)        flg_tag = "R11 center flag";
        else                     flg_tag = "R10 flag";
        @(posedge clk);
        @(negedge clk);
        m_cnt = n_cnt; m_up = n_up; m_pwm = n_pwm; m_flag = n_flag;
        check(cnt_tag, int'(count), m_cnt);
        check(pwm_tag, int'(pwm_ref), int'(m_pwm));
        check(flg_tag, int'(cmp_flag), int'(m_flag));
    endtask

    task automatic run_dir(int al, bit dn, int rl, int cv, int n);
        align_sel = al[1:0]; dir_down = dn;
        reload = CNT_W'(rl); cmp_val = CNT_W'(cv);
        en = 1'b1; flag_clr = 1'b0;
        for (int i = 0; i < n; i++) begin
            flag_clr = (i % 7 == 6);
            step();
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        check("R1 reset count", int'(count), 0);
        check("R1 reset pwm", int'(pwm_ref), 0);
        check("R1 reset flag", int'(cmp_flag), 0);
        rst_n = 1'b1;
        m_cnt = 0; m_up = 1'b1; m_pwm = 1'b0; m_flag = 1'b0;

        // edge-aligned, rising, limit 8
        run_dir(0, 0, 8, 4, 20);
        run_dir(0, 0, 8, 8, 20);
        run_dir(0, 0, 8, 9, 20);
        run_dir(0, 0, 8, 0, 20);
        // edge-aligned, falling
        run_dir(0, 1, 8, 4, 20);
        run_dir(0, 1, 8, 0, 20);
        run_dir(0, 1, 8, 12, 20);
        // center, each flag filter
        run_dir(1, 0, 8, 3, 40);
        run_dir(2, 0, 8, 3, 40);
        run_dir(3, 0, 8, 8, 40);
        run_dir(3, 0, 0, 0, 10);
        // R10: clear held across a match, set must win
        align_sel = 2'b00; dir_down = 1'b0; reload = CNT_W'(8); cmp_val = CNT_W'(2);
        en = 1'b1; flag_clr = 1'b1;
        repeat (20) step();
        // R5: disabled with a match present
        en = 1'b0; flag_clr = 1'b0;
        repeat (5) step();

        for (int seg = 0; seg < 60; seg++) begin
            align_sel = (($urandom % 2) == 0) ? 2'b00 : 2'($urandom % 4);
            dir_down  = 1'($urandom % 2);
            reload    = CNT_W'($urandom % 11);
            cmp_val   = CNT_W'($urandom % 14);
            for (int i = 0; i < 40; i++) begin
                en       = (($urandom % 10) != 0);
                flag_clr = (($urandom % 6) == 0);
                if (($urandom % 16) == 0) cmp_val = CNT_W'($urandom % 14);
                step();
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule